// File: doc/BRIEF.md
# Programmable Sampled Delay Line

This block reproduces a one-bit sampled signal on its output after a programmable number of clock periods. An 8-bit delay code chooses the extra latency on top of a fixed base latency. A separate reference output carries the same signal at a fixed latency that is exactly one period longer than the zero-code path. A consumer can therefore measure the programmed delay against the reference rather than against the raw input. The delay window may be far longer than any input pulse, and every transition inside it is kept, so a periodic signal can be shifted by a full period or more.

A mode input selects what the two outputs carry. In delay mode the main output is the delayed copy and the auxiliary output is the reference copy. In pulse mode the main output is the inverted delayed copy and the auxiliary output forwards a pulse signal produced by a neighbouring block. If the inverted main output is fed back to the input, the arrangement forms a ring oscillator whose period is set by the code.

The sample history sits in a circular single-bit memory with a registered read, which maps onto block RAM. A fill counter makes samples taken before the last reset read as 0.

Top module: `sampled_delay_line`

## Requirements
- R1: While reset is high at a clock edge, both outputs are 0 after that edge.
- R2: In delay mode (mode_sel = 0), main_out after edge m equals smp_in sampled at edge m − (LAT_BASE + c), where c is the unsigned value of dly_code at edge m − 1 (LAT_BASE defaults to 4).
- R3: In delay mode, aux_out after edge m equals smp_in sampled at edge m − (LAT_BASE + 1), whatever the code.
- R4: In pulse mode (mode_sel = 1), main_out after edge m is the complement of the sample that R2 would select.
- R5: In pulse mode, aux_out after edge m equals pulse_in sampled at edge m.
- R6: Every transition of the input inside the delay window is reproduced. Rising and falling edges get the same delay, including single-cycle pulses at code 255.
- R7: A change of dly_code acts on the tap choice at the very next edge. After that edge the output follows R2 with the new code, and there are no settling cycles.
- R8: Samples taken before a reset never appear on an output after it. Positions that have not been written since reset read as 0.
- R9: In pulse mode with smp_in driven from main_out of the previous cycle, main_out toggles every LAT_BASE + c + 1 cycles.
- R10: A change of mode_sel acts on both outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 1 | Sampled input bit |
| dly_code | input | CODE_W | Delay code; 0 is the shortest delay |
| mode_sel | input | 1 | 0: delayed and reference; 1: inverted delayed and pulse |
| pulse_in | input | 1 | Pulse signal from a neighbouring block, forwarded in pulse mode |
| main_out | output | 1 | Delayed (or inverted delayed) copy of smp_in |
| aux_out | output | 1 | Reference copy or forwarded pulse |

## Verification
The assertions assume LAT_BASE is at least 2, so that the read position never equals the position being written. They also assume that dly_code, mode_sel and pulse_in change only between clock edges. The assertions that compare the reference output with the previous main output wait four edges after reset and require the code to have been 0 two edges earlier. The stimulus drives every input on the falling edge and keeps codes inside the 8-bit range. It holds the code at the values under test long enough for those comparisons to trigger, and it switches mode at points where they can be seen.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic {
    SEL_DELAY = 1'b0,
    SEL_PULSE = 1'b1
  } out_sel_e;

  // address width able to hold the longest read distance
  function automatic int hist_aw(input int code_w, input int base);
    return $clog2(base + (1 << code_w) - 1);
  endfunction

endpackage

// File: rtl/sdl_hist_ram.sv
// Circular one-bit sample history with a registered read port.
// A fill counter marks positions not yet written since reset.
module sdl_hist_ram #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [AW-1:0] rd_dist,
  output logic          rd_bit
);
  localparam int WORDS = 1 << AW;

  logic          mem [WORDS];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] fill;
  logic [AW-1:0] rd_addr;
  logic          rd_raw;
  logic          vld_q;

  assign rd_addr = wr_ptr - rd_dist;

  // storage path: no reset, so it can map onto block RAM
  always_ff @(posedge clk) begin
    if (!rst) begin
      mem[wr_ptr] <= din;
    end
    rd_raw <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      fill   <= '0;
      vld_q  <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + 1'b1;
      if (fill != '1) begin
        fill <= fill + 1'b1;
      end
      vld_q <= (rd_dist <= fill);
    end
  end

  assign rd_bit = rd_raw & vld_q;

endmodule

// File: rtl/sdl_ref_tap.sv
// Fixed-length flop chain feeding the reference output.
module sdl_ref_tap #(
  parameter int STAGES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic tap
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  assign tap = chain[STAGES-1];

endmodule

// File: rtl/sdl_out_stage.sv
// Registered output selection by mode.
module sdl_out_stage
  import sdl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  out_sel_e sel,
  input  logic     dly_bit,
  input  logic     ref_bit,
  input  logic     pulse_bit,
  output logic     main_out,
  output logic     aux_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      main_out <= 1'b0;
      aux_out  <= 1'b0;
    end else begin
      case (sel)
        SEL_DELAY: begin
          main_out <= dly_bit;
          aux_out  <= ref_bit;
        end
        default: begin
          main_out <= ~dly_bit;
          aux_out  <= pulse_bit;
        end
      endcase
    end
  end

endmodule

// File: rtl/sampled_delay_line.sv
// LAT_BASE must be at least 2.
module sampled_delay_line
  import sdl_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int LAT_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_in,
  input  logic [CODE_W-1:0] dly_code,
  input  logic              mode_sel,
  input  logic              pulse_in,
  output logic              main_out,
  output logic              aux_out
);
  localparam int AW         = hist_aw(CODE_W, LAT_BASE);
  localparam int REF_STAGES = LAT_BASE + 1;

  logic [AW-1:0] tap_dist;
  logic          hist_bit;
  logic          ref_bit;
  out_sel_e      sel;

  // read distance: one memory read stage plus the output register
  assign tap_dist = AW'(LAT_BASE - 1) + AW'(dly_code);
  assign sel      = out_sel_e'(mode_sel);

  sdl_hist_ram #(.AW(AW)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .din     (smp_in),
    .rd_dist (tap_dist),
    .rd_bit  (hist_bit)
  );

  sdl_ref_tap #(.STAGES(REF_STAGES)) u_ref (
    .clk (clk),
    .rst (rst),
    .din (smp_in),
    .tap (ref_bit)
  );

  sdl_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .dly_bit   (hist_bit),
    .ref_bit   (ref_bit),
    .pulse_bit (pulse_in),
    .main_out  (main_out),
    .aux_out   (aux_out)
  );

endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dly_code,
  input logic              mode_sel,
  input logic              pulse_in,
  input logic              main_out,
  input logic              aux_out
);
  logic [1:0] age;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  always @(posedge clk) begin
    if (rst_q == 1'b1) begin
      reset_clear_chk: assert (main_out == 1'b0 && aux_out == 1'b0)
        else $error("outputs not cleared by reset");
    end
  end

  // R3
  ref_after_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !mode_sel && !$past(mode_sel) && $past(dly_code, 2) == '0)
    |=> (aux_out == $past(main_out)));

  // R4
  invert_vs_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !mode_sel && $past(mode_sel) && $past(dly_code, 2) == '0)
    |=> (aux_out != $past(main_out)));

  // R5
  pulse_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    mode_sel |=> (aux_out == $past(pulse_in)));

endmodule

bind sampled_delay_line sdl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dly_code (dly_code),
  .mode_sel (mode_sel),
  .pulse_in (pulse_in),
  .main_out (main_out),
  .aux_out  (aux_out)
);

// File: tb/sim_sampled_delay_line.sv
`timescale 1ns/1ps
module sim_sampled_delay_line;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_in = 1'b0;
  logic [7:0] dly_code = 8'd0;
  logic       mode_sel = 1'b0;
  logic       pulse_in = 1'b0;
  logic       main_out, aux_out;

  int checks = 0;
  int errors = 0;
  string main_tag = "R2";
  string aux_tag  = "R3";

  logic in_h[$];
  int   code_h[$];
  logic mode_h[$];
  logic pulse_h[$];

  always #2 clk = ~clk;

  sampled_delay_line #(.CODE_W(8), .LAT_BASE(LAT)) u0 (
    .clk(clk), .rst(rst), .smp_in(smp_in), .dly_code(dly_code),
    .mode_sel(mode_sel), .pulse_in(pulse_in),
    .main_out(main_out), .aux_out(aux_out)
  );

  function automatic logic hin(input int i);
    if (i < 0) return 1'b0;
    return in_h[i];
  endfunction

  task automatic expect_bit(input string tag, input string what,
                            input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_out();
    int   m;
    logic x, em, ea;
    m  = in_h.size() - 1;
    x  = (m == 0) ? 1'b0 : hin(m - LAT - code_h[m-1]);
    em = mode_h[m] ? ~x : x;
    ea = mode_h[m] ? pulse_h[m] : hin(m - 1 - LAT);
    expect_bit(main_tag, "main_out", main_out, em);
    expect_bit(aux_tag, "aux_out", aux_out, ea);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic tick(input logic i, input int c, input logic md,
                      input logic p, input logic fb);
    if (in_h.size() > 0) check_out();
    smp_in   = fb ? main_out : i;
    dly_code = 8'(c);
    mode_sel = md;
    pulse_in = p;
    in_h.push_back(smp_in);
    code_h.push_back(c);
    mode_h.push_back(md);
    pulse_h.push_back(p);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_h.delete(); code_h.delete(); mode_h.delete(); pulse_h.delete();
    repeat (3) @(negedge clk);
    expect_bit("R1", "main_out in reset", main_out, 1'b0);
    expect_bit("R1", "aux_out in reset", aux_out, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int last_t;
    logic prev;
    int nchg;
    @(negedge clk);
    do_reset();

    // R2 / R3: code 0, then code 37, random input
    main_tag = "R2"; aux_tag = "R3";
    for (int k = 0; k < 200; k++) tick(1'($urandom), 0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 200; k++) tick(1'($urandom), 37, 1'b0, 1'b0, 1'b0);

    // R6: single-cycle pulses and slow square at the longest code
    main_tag = "R6";
    for (int k = 0; k < 400; k++) tick((k % 7) == 0, 255, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 400; k++) tick((k / 3) % 2 == 1, 255, 1'b0, 1'b0, 1'b0);

    // R7: code changes every few cycles
    main_tag = "R7";
    for (int k = 0; k < 300; k++) tick(1'($urandom), (k / 5) * 13 % 256, 1'b0, 1'b0, 1'b0);

    // R4 / R5: pulse mode
    main_tag = "R4"; aux_tag = "R5";
    for (int k = 0; k < 300; k++) tick(1'($urandom), 20, 1'b1, 1'($urandom), 1'b0);

    // R10: mode toggling, including at code 0
    main_tag = "R10"; aux_tag = "R10";
    for (int k = 0; k < 300; k++)
      tick(1'($urandom), (k < 150) ? 0 : 9, (k / 4) % 2 == 1, 1'($urandom), 1'b0);

    // R8: ones before a reset must not come back
    main_tag = "R8"; aux_tag = "R8";
    for (int k = 0; k < 300; k++) tick(1'b1, 255, 1'b0, 1'b0, 1'b0);
    do_reset();
    for (int k = 0; k < 300; k++) tick(1'b0, 255, 1'b0, 1'b0, 1'b0);

    // R9: ring oscillator through the inverted output
    do_reset();
    main_tag = "R4"; aux_tag = "R5";
    for (int k = 0; k < 300; k++) tick(1'b0, 10, 1'b1, 1'b0, 1'b0);
    main_tag = "R9"; aux_tag = "R9";
    prev = main_out; last_t = 0; nchg = 0;
    for (int t = 1; t <= 240; t++) begin
      tick(1'b0, 10, 1'b1, 1'b0, 1'b1);
      if (main_out != prev) begin
        if (nchg > 0) begin
          checks++;
          if (t - last_t != LAT + 10 + 1) begin
            errors++;
            $display("FAIL R9 toggle interval actual=%0d expected=%0d", t - last_t, LAT + 11);
          end
        end
        nchg++;
        last_t = t;
        prev = main_out;
      end
    end
    checks++;
    if (nchg < 10) begin
      errors++;
      $display("FAIL R9 toggle count actual=%0d expected>=10", nchg);
    end

    tick(1'b0, 10, 1'b1, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule